// File: doc/BRIEF.md
# External Bus Sequencer with Wait States

This block sits between a processor core and an asynchronous external memory bus. The core offers one request at a time: an address, write data and a direction flag. The sequencer latches the request and drives the address, the write data, the active-low read and write strobes and the data-bus drive enable. It returns read data together with a one-clock completion pulse.

Timing is counted in machine cycles of two clocks each. A clock-enable phase toggle marks the first and second half of each machine cycle, so the whole block runs on one clock. A read with no waits takes one machine cycle. A write always takes two. The data-bus driver is switched on in the middle of the write's first machine cycle and switched off in the middle of its last one, which keeps it clear of any read. Accesses are stretched by whole machine cycles. Each access first spends a software-programmed number of extra cycles, then extends further while the external ready input is found low.

Top module: `ebus_ctrl`

## Requirements
- R1: During and after reset, with no access in progress, busy_o=0, ack_o=0, rd_n_o=1, wr_n_o=1 and bus_oe_o=0. Asserting rst_ni low in the middle of an access returns these outputs to these values at once.
- R2: A read accepted at a clock edge with ws_cfg_i=0 and rdy_i=1 keeps rd_n_o low for exactly 2 clocks. ack_o is then high in the 3rd clock after acceptance, and rdata_o at that point equals the bus_rdata_i value present at the end of the read.
- R3: A write accepted with ws_cfg_i=0 and rdy_i=1 occupies two machine cycles (4 clocks). ack_o is high in the 5th clock after acceptance.
- R4: For a write, bus_oe_o rises in the second clock of the first machine cycle and falls after the first clock of the final machine cycle, so it is high for 2*(first-cycle length in machine cycles) clocks. bus_oe_o is never high while rd_n_o is low.
- R5: ws_cfg_i (3 bits, value 0..7, captured at acceptance) adds that many machine cycles to a read, or to the first machine cycle of a write.
- R6: rdy_i is sampled only at the end of a machine cycle and only after the software count has run out. Each such sample found low adds one machine cycle. rdy_i low during software wait cycles has no effect. The first stage of the access therefore lasts max(ws, L)+1 machine cycles, where L is the number of leading machine cycles with rdy_i low.
- R7: A request is accepted only while busy_o=0. busy_o is high from the clock after acceptance until the last clock of the access. req_i held high during an access starts nothing new.
- R8: ack_o is high for exactly one clock per access, and busy_o is low whenever ack_o is high. A write leaves rdata_o unchanged.
- R9: bus_addr_o holds the latched address for the whole access, even if addr_i changes. wr_n_o is low only while bus_oe_o is high, with bus_wdata_o equal to the latched write data. wr_n_o is low for one clock less than bus_oe_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request from the core |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Request address |
| wdata_i | input | DATA_W | Request write data |
| ws_cfg_i | input | WS_W | Software wait-state count |
| busy_o | output | 1 | Access in progress |
| ack_o | output | 1 | One-clock completion pulse |
| rdata_o | output | DATA_W | Read data captured at completion |
| bus_addr_o | output | ADDR_W | External address |
| bus_wdata_o | output | DATA_W | External write data |
| bus_rdata_i | input | DATA_W | External read data |
| bus_oe_o | output | 1 | External data-bus drive enable |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| rdy_i | input | 1 | External ready |

## Verification
The bench times each access from its acceptance edge to the completion pulse. It covers every mix of software waits and ready-low cycles, including ready held low only during the software wait cycles: a design that samples ready too early would stretch those accesses by extra cycles. It counts the clocks of bus drive and of each strobe, so a driver turned on at the machine-cycle edge instead of mid-cycle, or left on into the next read, changes a count or shows as a drive clash. It holds the request line high with scrambled address and data for the whole access, so a design that re-accepts while busy, or lets the address follow the core, is caught. It also resets in the middle of a stalled read to check that the strobes release.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR_A = 2'd2,
    ST_WR_B = 2'd3
  } ebus_state_e;
endpackage

// File: rtl/ebus_phase.sv
module ebus_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic ph_o,
  output logic mc_end_o
);
  logic ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ph_q <= 1'b0;
    else if (!run_i) ph_q <= 1'b0;
    else             ph_q <= ~ph_q;
  end

  assign ph_o     = ph_q;
  assign mc_end_o = run_i & ph_q;
endmodule

// File: rtl/ebus_wait.sv
module ebus_wait #(
  parameter int WS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [WS_W-1:0] load_val_i,
  input  logic            dec_i,
  output logic            zero_o
);
  logic [WS_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ebus_ctrl.sv
module ebus_ctrl
  import ebus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int WS_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [WS_W-1:0]   ws_cfg_i,
  output logic              busy_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              bus_oe_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  input  logic              rdy_i
);
  ebus_state_e       state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              first_q, ack_q;
  logic              busy, ph, mc_end, ws_zero, accept, stage_done, wait_dec;

  assign busy       = (state_q != ST_IDLE);
  assign accept     = !busy && req_i;
  // software count first, then ready
  assign stage_done = mc_end && ws_zero && rdy_i;
  assign wait_dec   = mc_end && (state_q == ST_RD || state_q == ST_WR_A);

  ebus_phase u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (busy),
    .ph_o    (ph),
    .mc_end_o(mc_end)
  );

  ebus_wait #(.WS_W(WS_W)) u_wait (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .load_val_i(ws_cfg_i),
    .dec_i     (wait_dec),
    .zero_o    (ws_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      first_q <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          first_q <= 1'b1;
          state_q <= we_i ? ST_WR_A : ST_RD;
        end
        ST_RD: if (stage_done) begin
          rdata_q <= bus_rdata_i;
          ack_q   <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_WR_A: if (mc_end) begin
          first_q <= 1'b0;
          if (stage_done) state_q <= ST_WR_B;
        end
        ST_WR_B: if (mc_end) begin
          ack_q   <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic drive_a, drive_b;
  // driver on mid first cycle, off mid final cycle
  assign drive_a = (state_q == ST_WR_A) && (ph || !first_q);
  assign drive_b = (state_q == ST_WR_B) && !ph;

  assign bus_oe_o    = drive_a || drive_b;
  assign wr_n_o      = !drive_a;
  assign rd_n_o      = (state_q != ST_RD);
  assign busy_o      = busy;
  assign ack_o       = ack_q;
  assign rdata_o     = rdata_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
endmodule

// File: rtl/ebus_chk.sv
module ebus_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              ack_o,
  input logic              bus_oe_o,
  input logic              rd_n_o,
  input logic              wr_n_o,
  input logic [ADDR_W-1:0] bus_addr_o
);
  assert_no_drive_clash_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && bus_oe_o));

  assert_oe_rise_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_oe_o) |-> !wr_n_o);

  assert_wr_driven_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_n_o |-> bus_oe_o);

  assert_addr_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(bus_addr_o));

  assert_ack_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  assert_ack_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !busy_o);

  assert_read_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_n_o) |=> !rd_n_o);
endmodule

bind ebus_ctrl ebus_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .ack_o     (ack_o),
  .bus_oe_o  (bus_oe_o),
  .rd_n_o    (rd_n_o),
  .wr_n_o    (wr_n_o),
  .bus_addr_o(bus_addr_o)
);

// File: tb/sim_ebus_ctrl.sv
`timescale 1ns/1ps
module sim_ebus_ctrl;
  localparam int AW = 16, DW = 16, WW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, rdy = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, din = '0;
  logic [WW-1:0] ws = '0;
  logic busy, ack, oe, rd_n, wr_n;
  logic [DW-1:0] rdata, bwdata;
  logic [AW-1:0] baddr;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ebus_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WS_W(WW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ws_cfg_i(ws), .busy_o(busy), .ack_o(ack),
    .rdata_o(rdata), .bus_addr_o(baddr), .bus_wdata_o(bwdata),
    .bus_rdata_i(din), .bus_oe_o(oe), .rd_n_o(rd_n), .wr_n_o(wr_n),
    .rdy_i(rdy)
  );

  typedef struct packed {
    logic          wr;
    logic [2:0]    wsc;
    logic [3:0]    low;
    logic [15:0]   a;
    logic [15:0]   d;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 3'd0, 4'd0, 16'h1000, 16'hBEEF},  // R2 plain read
    '{1'b1, 3'd0, 4'd0, 16'h2002, 16'h1234},  // R3 plain write
    '{1'b0, 3'd2, 4'd0, 16'h3004, 16'h0F0F},  // R5
    '{1'b0, 3'd0, 4'd3, 16'h4006, 16'hA55A},  // R6 ready stall
    '{1'b0, 3'd3, 4'd2, 16'h5008, 16'h7E7E},  // R6 ready low only in sw waits
    '{1'b1, 3'd1, 4'd2, 16'h600A, 16'hC3C3},  // R4 R6 write stall
    '{1'b0, 3'd7, 4'd0, 16'h700C, 16'h0001},  // R5 max count
    '{1'b1, 3'd7, 4'd9, 16'h800E, 16'hFFFE},  // R5 R6 write
    '{1'b0, 3'd1, 4'd4, 16'h9010, 16'h5A5A}   // R6 ready beyond sw
  };

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    int mca, mc, ack_at, rd_lo, oe_hi, wr_lo, clash, busy_bad, addr_bad, wd_bad;
    logic [DW-1:0] prev_rd, exp_rd;
    string rq;
    mca = ((v.wsc > v.low) ? int'(v.wsc) : int'(v.low)) + 1;
    mc  = v.wr ? mca + 1 : mca;
    rq  = v.wr ? "R3" : "R2";
    exp_rd = v.d ^ 16'hA5A5;
    ack_at = 0; rd_lo = 0; oe_hi = 0; wr_lo = 0;
    clash = 0; busy_bad = 0; addr_bad = 0; wd_bad = 0;
    @(negedge clk);
    prev_rd = rdata;
    req = 1'b1; we = v.wr; addr = v.a; wdata = v.d; ws = v.wsc;
    din = exp_rd; rdy = 1'b1;
    @(posedge clk);
    for (int n = 1; n <= 80; n++) begin
      @(negedge clk);
      // R7: request stays high with scrambled fields while busy
      addr = ~v.a; wdata = ~v.d; ws = 3'd5; we = ~v.wr;
      rdy = (((n - 1) / 2) >= int'(v.low));
      if (ack) begin ack_at = n; req = 1'b0; break; end
      if (!busy) busy_bad++;
      if (baddr != v.a) addr_bad++;
      if (!rd_n) rd_lo++;
      if (oe) oe_hi++;
      if (!wr_n) begin
        wr_lo++;
        if (bwdata != v.d) wd_bad++;
      end
      if (!rd_n && oe) clash++;
    end
    chk(ack_at == 2*mc + 1, rq, "R5 R6 ack latency", ack_at, 2*mc + 1);
    chk(busy_bad == 0, "R7", "busy low during access", busy_bad, 0);
    chk(addr_bad == 0, "R9", "address held", addr_bad, 0);
    chk(clash == 0, "R4", "drive clash", clash, 0);
    if (v.wr) begin
      chk(oe_hi == 2*mca, "R4", "drive enable clocks", oe_hi, 2*mca);
      chk(wr_lo == 2*mca - 1, "R9", "write strobe clocks", wr_lo, 2*mca - 1);
      chk(wd_bad == 0, "R9", "write data on bus", wd_bad, 0);
      chk(rdata == prev_rd, "R8", "rdata kept on write", rdata, prev_rd);
      chk(rd_lo == 0, "R3", "no read strobe", rd_lo, 0);
    end else begin
      chk(rd_lo == 2*mc, "R2", "read strobe clocks", rd_lo, 2*mc);
      chk(rdata == exp_rd, "R2", "read data", rdata, exp_rd);
      chk(oe_hi == 0, "R4", "no drive on read", oe_hi, 0);
    end
    @(negedge clk);
    chk(!ack, "R8", "ack single pulse", ack, 0);
    chk(!busy, "R7", "no re-accept after done", busy, 0);
  endtask

  initial begin
    #1;
    chk(!busy && !ack && rd_n && wr_n && !oe, "R1", "state in reset",
        {busy, ack, rd_n, wr_n, oe}, 5'b00110);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !ack && rd_n && wr_n && !oe, "R1", "idle after reset",
        {busy, ack, rd_n, wr_n, oe}, 5'b00110);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R1: reset during a stalled read
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 16'h0ABC; ws = '0; rdy = 1'b0;
    @(posedge clk);
    @(negedge clk) req = 1'b0;
    repeat (3) @(negedge clk);
    chk(!rd_n && busy, "R1", "read stalled before reset", {busy, rd_n}, 2'b10);
    rst_n = 1'b0;
    #1;
    chk(!busy && !ack && rd_n && wr_n && !oe, "R1", "mid-access reset",
        {busy, ack, rd_n, wr_n, oe}, 5'b00110);
    @(negedge clk) rst_n = 1'b1;
    rdy = 1'b1;
    @(negedge clk);
    chk(!busy, "R1", "idle after mid reset", busy, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule